// File: doc/BRIEF.md
# Clock Source Selection Controller

This block decides which of three clocks drives the internal system clock: the oscillator reference (optionally halved), the output of a PLL multiplier, or a slow free-running clock that the PLL produces while its loop is disabled. Software programs a control register and a PLL configuration register through a simple synchronous write port and can read both back unchanged. Two status inputs, PLL lock and regulator ready, come from separate blocks and gate the selection.

From the stored fields the controller derives the PLL enable, the multiplication factor, the post-divide factor and the overall frequency ratio relative to the oscillator as a numerator and denominator pair. A flag is raised when that ratio exceeds a limit set by parameters. The clock multiplexer and the analog loop are outside this block; it only produces the source choice and the ratio values they use.

Top module: `clksrc_ctrl`

## Requirements
- R1: After reset the control register reads 3'b001 (prescale on, select request off, free-run off) and the PLL register reads 5'b11100 (multiplier code 0, divider code 7); `pll_en` is 0 and `src_sel` is 0.
- R2: Address 0 holds the control register (bit 0 prescale, bit 1 select request, bit 2 free-run enable) and address 1 the PLL register (bits 1:0 multiplier code, bits 4:2 divider code); `rd_data` returns the stored fields in those positions and zero elsewhere, and zero for other addresses.
- R3: Multiplier codes 0, 1, 2, 3 give `mul_factor` 6, 8, 10, 14.
- R4: Divider codes 0 to 6 give `pll_en` = 1 and `div_factor` = code + 1; code 7 gives `pll_en` = 0 and `div_factor` = 0.
- R5: `ref_halved` follows the prescale bit; while the PLL is enabled `ratio_den` = `div_factor` × 2 when halved and × 1 otherwise, and 0 while it is disabled.
- R6: With the select request clear, `src_sel` is 0 (reference).
- R7: With the select request set and the PLL enabled, `src_sel` is 1 (PLL) only when `pll_lock` and `vreg_rdy` are both high, and 0 otherwise.
- R8: With the select request set, divider code 7 and free-run enabled, `src_sel` is 2 (slow clock) whenever `vreg_rdy` is high, whatever `pll_lock` is; with free-run disabled it is 0.
- R9: A write to the control register changes the free-run enable only if the select request was clear before that write; otherwise the stored free-run bit is kept.
- R10: `over_limit` is 1 exactly when the PLL is enabled and `mul_factor` × LIM_DEN > LIM_NUM × `ratio_den`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data for `rd_addr` |
| pll_lock | input | 1 | PLL locked status |
| vreg_rdy | input | 1 | Regulator supply stable |
| src_sel | output | 2 | Chosen source: 0 reference, 1 PLL, 2 slow clock |
| pll_en | output | 1 | PLL loop enable |
| ref_halved | output | 1 | Reference is oscillator divided by two |
| mul_factor | output | 4 | PLL multiplication factor |
| div_factor | output | DIV_W | Post-divide factor, 0 when PLL is off |
| ratio_den | output | DIV_W+1 | Ratio denominator relative to oscillator |
| over_limit | output | 1 | Ratio above configured maximum |

## Verification
The hardest state to reach is a control write that tries to change the free-run enable while the select request is already set, especially one that clears the request and the free-run bit in the same write. The stimulus first enables free-run with the request clear, turns the PLL off, sets the request, then issues such writes and reads the control register back while watching `src_sel` remain on the slow clock. A behavioural model in the bench, holding its own copy of the registers with the hold rule, compares every output on every cycle through a long stretch of random writes and status toggles.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

   typedef enum logic [1:0] {
      SRC_REF  = 2'd0,
      SRC_PLL  = 2'd1,
      SRC_SLOW = 2'd2
   } clk_src_e;

   localparam int REG_CTRL = 0;
   localparam int REG_PLL  = 1;

   localparam int CTRL_PRE  = 0;
   localparam int CTRL_SEL  = 1;
   localparam int CTRL_FREE = 2;

   function automatic logic [3:0] mul_decode(input logic [1:0] code);
      logic [3:0] f;
      case (code)
         2'd0:    f = 4'd6;
         2'd1:    f = 4'd8;
         2'd2:    f = 4'd10;
         default: f = 4'd14;
      endcase
      return f;
   endfunction

endpackage

// File: rtl/clksrc_cfg.sv
module clksrc_cfg
   import clksrc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2,
   parameter int MUL_W  = 2,
   parameter int DIV_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              prediv_q,
   output logic              sel_q,
   output logic              free_q,
   output logic [MUL_W-1:0]  mul_q,
   output logic [DIV_W-1:0]  div_q
);

   localparam logic [DIV_W-1:0] DIV_OFF = {DIV_W{1'b1}};
   localparam int PLL_BITS = MUL_W + DIV_W;

   if (DATA_W < PLL_BITS || DATA_W < 3) begin : g_bad_width
      $error("clksrc_cfg: DATA_W too narrow for register fields");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prediv_q <= 1'b1;
         sel_q    <= 1'b0;
         free_q   <= 1'b0;
         mul_q    <= '0;
         div_q    <= DIV_OFF;
      end else if (wr_en) begin
         if (int'(wr_addr) == REG_CTRL) begin
            prediv_q <= wr_data[CTRL_PRE];
            sel_q    <= wr_data[CTRL_SEL];
            if (!sel_q) begin
               free_q <= wr_data[CTRL_FREE];
            end
         end else if (int'(wr_addr) == REG_PLL) begin
            mul_q <= wr_data[MUL_W-1:0];
            div_q <= wr_data[MUL_W +: DIV_W];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (int'(rd_addr) == REG_CTRL) begin
         rd_data[CTRL_PRE]  = prediv_q;
         rd_data[CTRL_SEL]  = sel_q;
         rd_data[CTRL_FREE] = free_q;
      end else if (int'(rd_addr) == REG_PLL) begin
         rd_data[PLL_BITS-1:0] = {div_q, mul_q};
      end
   end

   // Free-run bit is frozen while the select request is held
   assert_free_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q |=> $stable(free_q));

endmodule

// File: rtl/clksrc_ratio.sv
module clksrc_ratio
   import clksrc_pkg::*;
#(
   parameter int MUL_W       = 2,
   parameter int DIV_W       = 3,
   parameter bit CHECK_LIMIT = 1'b1,
   parameter int LIM_NUM     = 4,
   parameter int LIM_DEN     = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             prediv,
   input  logic [MUL_W-1:0] mul_code,
   input  logic [DIV_W-1:0] div_code,
   output logic             pll_en,
   output logic [3:0]       mul_factor,
   output logic [DIV_W-1:0] div_factor,
   output logic [DIV_W:0]   ratio_den,
   output logic             over_limit
);

   localparam logic [DIV_W-1:0] DIV_OFF = {DIV_W{1'b1}};

   if (MUL_W != 2) begin : g_bad_mul
      $error("clksrc_ratio: multiplier table needs a 2-bit code");
   end
   if (LIM_NUM < 1 || LIM_DEN < 1) begin : g_bad_lim
      $error("clksrc_ratio: limit terms must be positive");
   end

   assign pll_en     = (div_code != DIV_OFF);
   assign mul_factor = mul_decode(mul_code);
   assign div_factor = pll_en ? div_code + DIV_W'(1) : '0;
   assign ratio_den  = !pll_en ? '0 :
                       prediv  ? {div_factor, 1'b0} : {1'b0, div_factor};

   if (CHECK_LIMIT) begin : g_limit
      logic [31:0] lhs, rhs;
      assign lhs        = 32'(mul_factor) * 32'(LIM_DEN);
      assign rhs        = 32'(ratio_den) * 32'(LIM_NUM);
      assign over_limit = pll_en && (lhs > rhs);
   end else begin : g_no_limit
      assign over_limit = 1'b0;
   end

   assert_mul_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mul_factor == 4'd6) || (mul_factor == 4'd8) ||
      (mul_factor == 4'd10) || (mul_factor == 4'd14));

   assert_den_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_en |-> (ratio_den == '0));

endmodule

// File: rtl/clksrc_select.sv
module clksrc_select
   import clksrc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sel_req,
   input  logic     pll_en,
   input  logic     free_en,
   input  logic     pll_lock,
   input  logic     vreg_rdy,
   output clk_src_e src
);

   always_comb begin
      src = SRC_REF;
      if (sel_req && vreg_rdy) begin
         if (pll_en) begin
            if (pll_lock) src = SRC_PLL;
         end else if (free_en) begin
            src = SRC_SLOW;
         end
      end
   end

   assert_ref_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_req |-> (src == SRC_REF));

   assert_pll_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_PLL) |-> (pll_en && pll_lock && vreg_rdy));

   assert_slow_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_SLOW) |-> (!pll_en && free_en && vreg_rdy));

endmodule

// File: rtl/clksrc_ctrl.sv
module clksrc_ctrl
   import clksrc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 2,
   parameter int DIV_W       = 3,
   parameter bit CHECK_LIMIT = 1'b1,
   parameter int LIM_NUM     = 4,
   parameter int LIM_DEN     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              pll_lock,
   input  logic              vreg_rdy,
   output logic [1:0]        src_sel,
   output logic              pll_en,
   output logic              ref_halved,
   output logic [3:0]        mul_factor,
   output logic [DIV_W-1:0]  div_factor,
   output logic [DIV_W:0]    ratio_den,
   output logic              over_limit
);

   localparam int MUL_W = 2;

   logic             prediv_q, sel_q, free_q;
   logic [MUL_W-1:0] mul_q;
   logic [DIV_W-1:0] div_q;
   clk_src_e         src;

   clksrc_cfg #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MUL_W(MUL_W), .DIV_W(DIV_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .prediv_q(prediv_q), .sel_q(sel_q), .free_q(free_q),
      .mul_q(mul_q), .div_q(div_q)
   );

   clksrc_ratio #(
      .MUL_W(MUL_W), .DIV_W(DIV_W), .CHECK_LIMIT(CHECK_LIMIT),
      .LIM_NUM(LIM_NUM), .LIM_DEN(LIM_DEN)
   ) u_ratio (
      .clk(clk), .rst_n(rst_n), .prediv(prediv_q), .mul_code(mul_q),
      .div_code(div_q), .pll_en(pll_en), .mul_factor(mul_factor),
      .div_factor(div_factor), .ratio_den(ratio_den), .over_limit(over_limit)
   );

   clksrc_select u_sel (
      .clk(clk), .rst_n(rst_n), .sel_req(sel_q), .pll_en(pll_en),
      .free_en(free_q), .pll_lock(pll_lock), .vreg_rdy(vreg_rdy), .src(src)
   );

   assign src_sel    = src;
   assign ref_halved = prediv_q;

   assert_limit_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
      over_limit |-> pll_en);

   assert_no_pll_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_en |-> (src_sel != 2'd1));

endmodule

// File: tb/tb_clksrc_ctrl.sv
module tb_clksrc_ctrl;

   localparam int DATA_W = 8, ADDR_W = 2, DIV_W = 3;
   localparam int LIM_NUM = 4, LIM_DEN = 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [DATA_W-1:0] rd_data;
   logic              pll_lock = 1'b0, vreg_rdy = 1'b0;
   logic [1:0]        src_sel;
   logic              pll_en, ref_halved, over_limit;
   logic [3:0]        mul_factor;
   logic [DIV_W-1:0]  div_factor;
   logic [DIV_W:0]    ratio_den;

   int checks = 0, fails = 0;

   // behavioural register shadow
   bit m_pre = 1, m_sel = 0, m_free = 0;
   int m_mul = 0, m_div = 7;

   always #5 clk = ~clk;

   clksrc_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W),
                 .CHECK_LIMIT(1'b1), .LIM_NUM(LIM_NUM), .LIM_DEN(LIM_DEN)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .pll_lock(pll_lock), .vreg_rdy(vreg_rdy), .src_sel(src_sel),
      .pll_en(pll_en), .ref_halved(ref_halved), .mul_factor(mul_factor),
      .div_factor(div_factor), .ratio_den(ratio_den), .over_limit(over_limit)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pre <= 1; m_sel <= 0; m_free <= 0; m_mul <= 0; m_div <= 7;
      end else if (wr_en) begin
         if (wr_addr == 0) begin
            m_pre <= wr_data[0];
            m_sel <= wr_data[1];
            if (!m_sel) m_free <= wr_data[2];
         end else if (wr_addr == 1) begin
            m_mul <= int'(wr_data[1:0]);
            m_div <= int'(wr_data[4:2]);
         end
      end
   end

   function automatic int exp_mul(int c);
      case (c)
         0: return 6;
         1: return 8;
         2: return 10;
         default: return 14;
      endcase
   endfunction

   // compare every output on every cycle against the model
   always @(negedge clk) begin
      if (rst_n) begin
         bit on;
         int den, src, rd;
         string stag;
         on  = (m_div != 7);
         den = on ? (m_div + 1) * (m_pre ? 2 : 1) : 0;
         src = 0;
         if (m_sel && vreg_rdy) begin
            if (on) src = pll_lock ? 1 : 0;
            else if (m_free) src = 2;
         end
         stag = !m_sel ? "R6 src" : (on ? "R7 src" : "R8 src");
         rd = (rd_addr == 0) ? (int'(m_free) * 4 + int'(m_sel) * 2 + int'(m_pre)) :
              (rd_addr == 1) ? (m_div * 4 + m_mul) : 0;
         chk(stag, int'(src_sel), src);
         chk("R4 pll_en", int'(pll_en), int'(on));
         chk("R4 div_factor", int'(div_factor), on ? m_div + 1 : 0);
         chk("R3 mul_factor", int'(mul_factor), exp_mul(m_mul));
         chk("R5 ref_halved", int'(ref_halved), int'(m_pre));
         chk("R5 ratio_den", int'(ratio_den), den);
         chk("R10 over_limit", int'(over_limit),
             int'(on && (exp_mul(m_mul) * LIM_DEN > LIM_NUM * den)));
         chk("R2 rd_data", int'(rd_data), rd);
      end
   end

   task automatic wr(int a, int d);
      @(posedge clk); #1;
      wr_en = 1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
      @(posedge clk); #1;
      wr_en = 0;
   endtask

   task automatic status(bit lk, bit vr);
      @(posedge clk); #1;
      pll_lock = lk; vreg_rdy = vr;
   endtask

   task automatic peek(int a, int exp, string tag);
      @(posedge clk); #1;
      rd_addr = ADDR_W'(a);
      @(negedge clk);
      chk(tag, int'(rd_data), exp);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      @(negedge clk);
      chk("R1 src_sel", int'(src_sel), 0);
      chk("R1 pll_en", int'(pll_en), 0);
      peek(0, 1, "R1 ctrl reset");
      peek(1, 5'b11100, "R1 pll reset");
      peek(2, 0, "R2 unmapped");

      // R3 R4 R5 R10 sweep over all codes and prescale settings
      for (int p = 0; p < 2; p++) begin
         wr(0, p);
         for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 8; d++) begin
               wr(1, d * 4 + m);
            end
         end
      end

      // R7 PLL selection gated by lock and regulator
      wr(0, 1);
      wr(1, 1 * 4 + 2);
      rd_addr = 0;
      status(0, 0);
      wr(0, 3);
      status(1, 0);
      status(0, 1);
      status(1, 1);
      @(negedge clk);
      chk("R7 pll chosen", int'(src_sel), 1);
      status(1, 0);
      @(negedge clk);
      chk("R7 regulator gate", int'(src_sel), 0);

      // R8 free-run clock, lock ignored
      wr(0, 1);
      wr(0, 5);
      wr(1, 7 * 4);
      wr(0, 7);
      status(0, 1);
      @(negedge clk);
      chk("R8 slow without lock", int'(src_sel), 2);
      status(0, 0);
      @(negedge clk);
      chk("R8 regulator gate", int'(src_sel), 0);
      status(1, 1);

      // R9 free-run change while selected is ignored
      wr(0, 3);
      peek(0, 7, "R9 free kept");
      @(negedge clk);
      chk("R9 src stays slow", int'(src_sel), 2);
      wr(0, 0);
      peek(0, 4, "R9 free kept on deselect");
      wr(0, 0);
      peek(0, 0, "R9 free cleared when idle");

      // random traffic
      for (int i = 0; i < 3000; i++) begin
         @(posedge clk); #1;
         wr_en    = ($urandom % 3) == 0;
         wr_addr  = ADDR_W'($urandom % 3);
         wr_data  = DATA_W'($urandom);
         rd_addr  = ADDR_W'($urandom % 3);
         pll_lock = $urandom % 2;
         vreg_rdy = ($urandom % 4) != 0;
      end
      @(posedge clk); #1 wr_en = 0;
      repeat (2) @(posedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule